// File: doc/BRIEF.md
# Fixed-Point Input Layer Convolver with Binary Weights

This block evaluates the input layer of a binarized convolutional network. A three-channel, 32×32 image of signed 20-bit fixed-point samples arrives in raster order, one sample per channel on each accepted beat. Every output position is a 3×3 window across all three channels, 27 terms in total, with zero padding at the image border. Each weight is a single bit, so a term is either added or subtracted and no multiplier is needed. The 27-term sum then passes through a per-map scale and offset, and only the sign of the result leaves the block. The output is one bit for each pixel.

A small configuration bank holds one 27-bit weight mask and one scale/offset pair for each of several output maps. Software fills the bank through a plain write port. A start pulse then selects one map and runs one pass over the image. The block holds two image rows plus three samples of history per channel. After the last input sample it supplies the trailing zero rows by itself, so the upstream source only has to provide the 1024 real samples.

Top module: `cnv_l1_binconv`

## Requirements
- R1: After reset, out_valid is 0 and stays 0 until a pass is started.
- R2: Weight bit index is ch*9 + ky*3 + kx, where ch is the channel (its sample sits at in_pix[ch*20 +: 20]), ky=0 is the row above the centre and kx=0 the column left of it. A bit of 1 adds that sample to the sum and a bit of 0 subtracts it.
- R3: Window samples that fall outside the 32×32 image contribute zero.
- R4: The result y = k·sum + h is computed at full precision. out_bit is 1 when y ≥ 0 and 0 when y < 0, so y = 0 gives 1.
- R5: Each pass emits exactly 1024 bits in raster order. out_last is 1 on the 1024th bit only.
- R6: While a pass runs, a cycle with in_valid low consumes no sample. While no pass runs, in_valid and in_pix have no effect.
- R7: On an accepted start, start_map is latched and selects the weights, k and h for the whole pass. A start that arrives while a pass or its results are still in flight is ignored.
- R8: With in_valid held high from the first sample on, the 1024 output bits appear on 1024 consecutive cycles. The trailing border needs no extra input.
- R9: A configuration write with cfg_fld=0 loads the weights from cfg_data[26:0]. cfg_fld=1 loads k from cfg_data[15:0], and cfg_fld=2 loads h from cfg_data[15:0]. cfg_fld=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_map | input | 2 | Map entry to write |
| cfg_fld | input | 2 | Field select: 0 weights, 1 k, 2 h |
| cfg_data | input | 32 | Write data |
| start | input | 1 | Begin one image pass |
| start_map | input | 2 | Map used by the pass |
| in_valid | input | 1 | Input sample triple is valid |
| in_pix | input | 60 | Three signed 20-bit samples, channel ch at [ch*20 +: 20] |
| out_valid | output | 1 | Output bit valid |
| out_bit | output | 1 | Binarized result, 1 = non-negative |
| out_last | output | 1 | Marks the final bit of the map |

## Verification
The assertions check the following on every cycle:
- The number of results between out_last markers is correct.
- The scan position holds during input stalls.
- The selected map stays fixed while a pass is in flight.
- The window sum never leaves its arithmetic range.

Only the bench scenarios can show the numerical result of each window. This covers weight polarity and bit order, the zeroing at all four borders, and the sign threshold at exactly zero. A mid-pass start request, gaps in the input and a write to the unused field are also checked only by comparing whole output maps against a model.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
    localparam int NCH  = 3;
    localparam int KS   = 3;
    localparam int NTAP = NCH * KS * KS;
    localparam int K_W  = 16;

    typedef struct packed {
        logic [NTAP-1:0]        wgt;
        logic signed [K_W-1:0]  k;
        logic signed [K_W-1:0]  h;
    } map_cfg_t;

    typedef enum logic [1:0] {
        FLD_WGT = 2'd0,
        FLD_K   = 2'd1,
        FLD_H   = 2'd2,
        FLD_NONE = 2'd3
    } cfg_fld_e;
endpackage

// File: rtl/cnv_window.sv
module cnv_window
    import cnv_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    parameter int PIX_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic [NCH*PIX_W-1:0]     in_pix,
    output logic                     active,
    output logic                     win_valid,
    output logic                     win_last,
    output logic signed [PIX_W-1:0]  win [NTAP]
);
    localparam int NPIX   = IMG_W * IMG_H;
    localparam int SCAN_N = NPIX + IMG_W + 1;
    localparam int SCAN_W = $clog2(SCAN_N + 1);
    localparam int NHIST  = 2 * IMG_W + 3;
    localparam int RW     = $clog2(IMG_H + 1);
    localparam int CW     = $clog2(IMG_W + 1);

    typedef struct packed {
        logic              run;
        logic [SCAN_W-1:0] s;
        logic [RW-1:0]     nr;
        logic [CW-1:0]     nc;
        logic [RW-1:0]     cr;
        logic [CW-1:0]     cc;
        logic              wv;
        logic              wl;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [PIX_W-1:0] hist_d [NCH][NHIST];
    logic [PIX_W-1:0] hist_q [NCH][NHIST];
    logic adv;

    always_comb begin
        st_d   = st_q;
        hist_d = hist_q;
        st_d.wv = 1'b0;
        st_d.wl = 1'b0;
        adv = st_q.run && ((st_q.s >= SCAN_W'(NPIX)) || in_valid);
        if (!st_q.run && start) st_d.run = 1'b1;
        if (adv) begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int j = NHIST - 1; j > 0; j--) hist_d[ch][j] = hist_q[ch][j-1];
                hist_d[ch][0] = (st_q.s < SCAN_W'(NPIX)) ? in_pix[ch*PIX_W +: PIX_W] : '0;
            end
            if (st_q.s >= SCAN_W'(IMG_W + 1)) begin
                st_d.wv = 1'b1;
                st_d.cr = st_q.nr;
                st_d.cc = st_q.nc;
                if (st_q.nc == CW'(IMG_W - 1)) begin
                    st_d.nc = '0;
                    st_d.nr = st_q.nr + 1'b1;
                end else begin
                    st_d.nc = st_q.nc + 1'b1;
                end
            end
            if (st_q.s == SCAN_W'(SCAN_N - 1)) begin
                st_d.wl  = 1'b1;
                st_d.run = 1'b0;
                st_d.s   = '0;
                st_d.nr  = '0;
                st_d.nc  = '0;
            end else begin
                st_d.s = st_q.s + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
        hist_q <= hist_d;
    end

    // Window gather with zero padding outside the image.
    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            for (int ky = 0; ky < KS; ky++) begin
                for (int kx = 0; kx < KS; kx++) begin
                    int r, c, j;
                    r = int'(st_q.cr) + ky - 1;
                    c = int'(st_q.cc) + kx - 1;
                    j = IMG_W + 1 - (ky - 1) * IMG_W - (kx - 1);
                    if (r >= 0 && r < IMG_H && c >= 0 && c < IMG_W)
                        win[ch*9 + ky*3 + kx] = hist_q[ch][j];
                    else
                        win[ch*9 + ky*3 + kx] = '0;
                end
            end
        end
    end

    assign active    = st_q.run;
    assign win_valid = st_q.wv;
    assign win_last  = st_q.wl;

    // R6: a starved beat during the input phase leaves the scan position alone
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.s < SCAN_W'(NPIX) && !in_valid) |=> $stable(st_q.s));
endmodule

// File: rtl/cnv_signsum.sv
module cnv_signsum
    import cnv_pkg::*;
#(
    parameter int PIX_W = 20,
    localparam int ACC_W = PIX_W + $clog2(NTAP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_v,
    input  logic                     in_last,
    input  logic signed [PIX_W-1:0]  win [NTAP],
    input  logic [NTAP-1:0]          wgt,
    output logic                     acc_v,
    output logic                     acc_last,
    output logic signed [ACC_W-1:0]  acc
);
    localparam longint ACC_LIM = longint'(NTAP) * (longint'(1) << (PIX_W - 1));

    typedef struct packed {
        logic                    v;
        logic                    last;
        logic signed [ACC_W-1:0] acc;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        logic signed [ACC_W-1:0] sum;
        sum = '0;
        for (int i = 0; i < NTAP; i++) begin
            if (wgt[i]) sum = sum + ACC_W'(win[i]);
            else        sum = sum - ACC_W'(win[i]);
        end
        st_d.v    = in_v;
        st_d.last = in_v && in_last;
        st_d.acc  = in_v ? sum : st_q.acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_v    = st_q.v;
    assign acc_last = st_q.last;
    assign acc      = st_q.acc;

    // R2: a 27-term signed sum can never exceed 27 full-scale samples
    a_r2_sum_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        acc_v |-> (longint'(acc) <= ACC_LIM && longint'(acc) >= -ACC_LIM));
endmodule

// File: rtl/cnv_affine.sv
module cnv_affine
    import cnv_pkg::*;
#(
    parameter int ACC_W = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_v,
    input  logic                    acc_last,
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [K_W-1:0]   k,
    input  logic signed [K_W-1:0]   h,
    output logic                    out_valid,
    output logic                    out_last,
    output logic                    out_bit
);
    localparam int Y_W = K_W + ACC_W + 1;

    typedef struct packed {
        logic v;
        logic last;
        logic b;
    } aff_st_t;

    aff_st_t st_d, st_q;

    always_comb begin
        logic signed [Y_W-1:0] ke, ae, he, y;
        ke = Y_W'(k);
        ae = Y_W'(acc);
        he = Y_W'(h);
        y  = ke * ae + he;
        st_d.v    = acc_v;
        st_d.last = acc_v && acc_last;
        st_d.b    = acc_v ? !y[Y_W-1] : st_q.b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v;
    assign out_last  = st_q.last;
    assign out_bit   = st_q.b;

    // R5: the end marker is only ever carried by a valid result
    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/cnv_l1_binconv.sv
module cnv_l1_binconv
    import cnv_pkg::*;
#(
    parameter int IMG_W  = 32,
    parameter int IMG_H  = 32,
    parameter int PIX_W  = 20,
    parameter int NMAPS  = 4,
    parameter int CFG_W  = 32,
    localparam int MAP_AW = (NMAPS > 1) ? $clog2(NMAPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [MAP_AW-1:0]     cfg_map,
    input  logic [1:0]            cfg_fld,
    input  logic [CFG_W-1:0]      cfg_data,
    input  logic                  start,
    input  logic [MAP_AW-1:0]     start_map,
    input  logic                  in_valid,
    input  logic [NCH*PIX_W-1:0]  in_pix,
    output logic                  out_valid,
    output logic                  out_bit,
    output logic                  out_last
);
    localparam int ACC_W = PIX_W + $clog2(NTAP);
    localparam int NPIX  = IMG_W * IMG_H;
    localparam int CNT_W = $clog2(NPIX + 1);

    typedef struct packed {
        map_cfg_t [NMAPS-1:0] bank;
        logic [MAP_AW-1:0]    map;
    } top_st_t;

    top_st_t st_d, st_q;
    map_cfg_t cur;
    logic active, win_v, win_l, acc_v, acc_l, busy;
    logic signed [PIX_W-1:0] win [NTAP];
    logic signed [ACC_W-1:0] acc;
    logic unused_cfg_hi;

    assign unused_cfg_hi = ^cfg_data;
    assign busy = active || win_v || acc_v;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_map) < NMAPS)) begin
            case (cfg_fld_e'(cfg_fld))
                FLD_WGT: st_d.bank[cfg_map].wgt = cfg_data[NTAP-1:0];
                FLD_K:   st_d.bank[cfg_map].k   = cfg_data[K_W-1:0];
                FLD_H:   st_d.bank[cfg_map].h   = cfg_data[K_W-1:0];
                default: ;
            endcase
        end
        if (start && !busy) st_d.map = start_map;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.bank[st_q.map];

    cnv_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .start(start && !busy),
        .in_valid(in_valid), .in_pix(in_pix), .active(active),
        .win_valid(win_v), .win_last(win_l), .win(win)
    );

    cnv_signsum #(.PIX_W(PIX_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .in_v(win_v), .in_last(win_l),
        .win(win), .wgt(cur.wgt),
        .acc_v(acc_v), .acc_last(acc_l), .acc(acc)
    );

    cnv_affine #(.ACC_W(ACC_W)) u_aff (
        .clk(clk), .rst_n(rst_n), .acc_v(acc_v), .acc_last(acc_l), .acc(acc),
        .k(cur.k), .h(cur.h),
        .out_valid(out_valid), .out_last(out_last), .out_bit(out_bit)
    );

    // Independent beat counter for the output framing checks.
    logic [CNT_W-1:0] beat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         beat_q <= '0;
        else if (out_valid) beat_q <= out_last ? '0 : beat_q + 1'b1;
    end

    // R5: the marker falls on the final result and on no earlier one
    a_r5_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (beat_q == CNT_W'(NPIX - 1)));
    a_r5_last_not_missed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q == CNT_W'(NPIX - 1)) |-> out_last);
    // R7: the selected map cannot change while results are in flight
    a_r7_map_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(st_q.map));
    // R1: nothing leaves the block in the cycles right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/cnv_l1_binconv_tb.sv
`timescale 1ns/1ps
module cnv_l1_binconv_tb;
    localparam int W = 32, H = 32, PW = 20, NP = W * H;

    typedef struct packed {
        logic [26:0]        w;
        logic signed [15:0] k;
        logic signed [15:0] h;
        logic [7:0]         seed;
        logic               gap;
        logic               cst;
    } vec_t;

    localparam vec_t TBL [4] = '{
        '{27'h5A5A5A5,  16'sd3,     16'sd1000,   8'd1,  1'b0, 1'b0},
        '{27'h7FFFFFF,  16'sd1,    -16'sd1800,   8'd0,  1'b0, 1'b1},
        '{27'h0123456, -16'sd5,    -16'sd20000,  8'd9,  1'b1, 1'b0},
        '{27'h7000E38,  16'sd2,     16'sd300,    8'd23, 1'b0, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, start = 0, in_valid = 0;
    logic [1:0] cfg_map = 0, cfg_fld = 0, start_map = 0;
    logic [31:0] cfg_data = 0;
    logic [3*PW-1:0] in_pix = 0;
    logic out_valid, out_bit, out_last;

    int checks = 0, fails = 0, cyc = 0;
    int ocnt = 0, last_idx = -1, first_cyc = 0, last_cyc = 0;
    bit got [NP];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cnv_l1_binconv u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_map(cfg_map),
        .cfg_fld(cfg_fld), .cfg_data(cfg_data), .start(start),
        .start_map(start_map), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (ocnt < NP) got[ocnt] = out_bit;
            if (ocnt == 0) first_cyc = cyc;
            if (out_last) begin last_idx = ocnt; last_cyc = cyc; end
            ocnt = ocnt + 1;
        end
    end

    function automatic int pix(vec_t v, int ch, int r, int c);
        if (v.cst) return 100;
        return (((r * 37 + c * 11 + ch * 101 + int'(v.seed) * 7) % 2001) - 1000) * 256;
    endfunction

    function automatic bit ref_bit(vec_t v, int r, int c);
        longint acc = 0;
        longint y;
        for (int ch = 0; ch < 3; ch++)
            for (int ky = 0; ky < 3; ky++)
                for (int kx = 0; kx < 3; kx++) begin
                    int rr = r + ky - 1;
                    int cc = c + kx - 1;
                    if (rr >= 0 && rr < H && cc >= 0 && cc < W) begin
                        if (v.w[ch*9 + ky*3 + kx]) acc += pix(v, ch, rr, cc);
                        else                      acc -= pix(v, ch, rr, cc);
                    end
                end
        y = longint'($signed(v.k)) * acc + longint'($signed(v.h));
        return y >= 0;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(int m, int f, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_map = 2'(m); cfg_fld = 2'(f); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic drive_pix(vec_t v, int idx);
        for (int ch = 0; ch < 3; ch++)
            in_pix[ch*PW +: PW] = PW'(pix(v, ch, idx / W, idx % W));
    endtask

    task automatic run_pass(int m, bit mid_start);
        vec_t v = TBL[m];
        ocnt = 0; last_idx = -1;
        @(negedge clk);
        start = 1; start_map = 2'(m);
        @(negedge clk);
        start = 0;
        for (int i = 0; i < NP; i++) begin
            if (v.gap && (i % 5 == 2)) begin
                in_valid = 0; in_pix = {3{20'hABCDE}};
                @(negedge clk);
            end
            in_valid = 1; drive_pix(v, i);
            if (mid_start && i == 500) begin start = 1; start_map = 2'((m + 1) % 4); end
            @(negedge clk);
            start = 0;
        end
        in_valid = 0;
        for (int t = 0; t < 200 && last_idx < 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_pass(int m, string req);
        vec_t v = TBL[m];
        check(ocnt == NP, "R5", "result count", ocnt, NP);
        check(last_idx == NP - 1, "R5", "last marker index", last_idx, NP - 1);
        for (int i = 0; i < NP; i++) begin
            bit e = ref_bit(v, i / W, i % W);
            check(got[i] == e, req, $sformatf("map %0d pixel %0d", m, i), got[i], e);
        end
        if (!v.gap)
            check(last_cyc - first_cyc == NP - 1, "R8", "result span in cycles",
                  last_cyc - first_cyc, NP - 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R6: idle block ignores input traffic
        in_valid = 1; in_pix = {3{20'h12345}};
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            check(out_valid == 0, "R1", "out_valid while idle", out_valid, 0);
        end
        in_valid = 0;
        // R9: program every map through the write port
        for (int m = 0; m < 4; m++) begin
            wr_cfg(m, 0, {5'b0, TBL[m].w});
            wr_cfg(m, 1, {16'hDEAD, TBL[m].k});
            wr_cfg(m, 2, {16'hBEEF, TBL[m].h});
        end
        wr_cfg(2, 3, 32'hFFFF_FFFF);   // R9: unused field must change nothing
        // Table walk: R2 polarity/order, R3+R4 via constant image, R6 gaps, R7 mid start
        for (int m = 0; m < 4; m++) begin
            run_pass(m, m == 3);
            check_pass(m, (m == 1) ? "R3/R4" : (m == 2) ? "R6/R9" : (m == 3) ? "R7" : "R2");
        end
        // R4: constant image, threshold corner/edge/interior directly
        run_pass(1, 0);
        check(got[0] == 0, "R4", "corner y<0", got[0], 0);
        check(got[1] == 1, "R4", "edge y==0 gives 1", got[1], 1);
        check(got[W + 1] == 1, "R4", "interior y>0", got[W + 1], 1);
        check(got[NP - 1] == 0, "R3", "far corner zero padded", got[NP - 1], 0);
        // R1: reset mid-pass leaves the outputs quiet
        @(negedge clk); start = 1; start_map = 0;
        @(negedge clk); start = 0; in_valid = 1;
        repeat (100) @(negedge clk);
        rst_n = 0; in_valid = 0;
        @(negedge clk); rst_n = 1;
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule